// File: doc/BRIEF.md
# Sample-Rate Speed Mode Detector

This block watches an audio frame clock (one period per sample) against a free-running reference clock and decides which of three speed bands the stream belongs to: single, double or quad speed. It reports the chosen band together with the oversampling ratio that a downstream interpolator should use for it: 128, 64 or 32. A lock flag tells the consumer whether the current frame rate is a legal, stable measurement.

The frame clock is brought into the reference domain through a synchronizer. The distance between consecutive rising edges is counted in reference cycles and compared against thresholds that are derived from the reference frequency and the band limits (50 kHz, 100 kHz, 200 kHz). A new band is adopted only after two measurements in a row agree. A frame rate above the top band, or a frame clock that stops, drops the lock while the last good band is held. A control bit switches the outputs from automatic detection to a mode taken from a two-bit field.

Top module: `rate_band_detector`

## Requirements
- R1: While reset is high and on the first cycle after reset, the mode output is 00 (single), the ratio output is 128 and the lock flag is 0.
- R2: The mode code is 00 = single, 01 = double, 10 = quad. The ratio output is always 128, 64 or 32 for those codes.
- R3: With P the number of reference cycles between two rising frame-clock edges, P >= ceil(REF_HZ/50000) selects single, P >= ceil(REF_HZ/100000) selects double, and P >= ceil(REF_HZ/200000) selects quad.
- R4: A measurement with P below ceil(REF_HZ/200000) clears the lock flag and leaves the mode unchanged.
- R5: A band is committed, and the lock flag set, only when two consecutive measurements fall into the same band. Alternating bands never change the committed mode.
- R6: When no rising edge arrives for ceil(REF_HZ/MIN_RATE_HZ) cycles, the lock flag clears and the mode is held. The next rising edge only restarts measuring, so three edges are needed to lock again.
- R7: With the auto bit at 0, the mode output follows the forced field one cycle later, and code 11 is taken as single. The lock flag keeps reporting the detector. Setting the auto bit back to 1 returns the detector's held mode.
- R8: The first rising edge after reset produces no measurement. A committed band reaches the outputs no later than 6 reference cycles after the rising edge that confirms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lrck_i | input | 1 | Frame clock, asynchronous to clk_i |
| auto_en_i | input | 1 | 1 = detected mode, 0 = forced mode |
| force_mode_i | input | 2 | Forced mode code (11 treated as single) |
| mode_o | output | 2 | Speed mode: 00 single, 01 double, 10 quad |
| osr_o | output | 8 | Oversampling ratio for the selected mode |
| lock_o | output | 1 | Detector holds a confirmed, legal rate |

## Verification
The bench builds the block with REF_HZ = 2,000,000 and MIN_RATE_HZ = 20,000. The band thresholds then fall at 40, 20 and 10 reference cycles and the timeout at 100 cycles. With these values every edge spacing from 8 to 60 cycles can be swept one by one, and each band edge is crossed on both sides. The same small values also make the timeout, the alternating-band sequences and the recovery after a stopped frame clock short enough to run in full.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10
  } speed_t;

  localparam int OSR_W = 8;

  function automatic logic [OSR_W-1:0] osr_of(input speed_t m);
    case (m)
      SPD_DOUBLE: osr_of = 8'd64;
      SPD_QUAD:   osr_of = 8'd32;
      default:    osr_of = 8'd128;
    endcase
  endfunction

  function automatic speed_t decode_force(input logic [1:0] f);
    case (f)
      2'b01:   decode_force = SPD_DOUBLE;
      2'b10:   decode_force = SPD_QUAD;
      default: decode_force = SPD_SINGLE;
    endcase
  endfunction

endpackage

// File: rtl/rbd_edge_sync.sv
module rbd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) pipe_q <= '0;
    else       pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // A detected edge lasts exactly one cycle (R3)
  p_rise_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);

endmodule

// File: rtl/rbd_period_meter.sv
module rbd_period_meter #(
  parameter int TO_CYC = 100,
  parameter int CW     = 7
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          rise_i,
  output logic          meas_vld_o,
  output logic [CW-1:0] period_o,
  output logic          stale_o
);

  localparam logic [CW-1:0] TO_C = CW'(TO_CYC);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_vld_o <= 1'b0;
      period_o   <= '0;
    end else begin
      meas_vld_o <= 1'b0;
      if (rise_i) begin
        if (armed_q) begin
          meas_vld_o <= 1'b1;
          period_o   <= cnt_q;
        end
        cnt_q   <= {{(CW-1){1'b0}}, 1'b1};
        armed_q <= 1'b1;
      end else if (cnt_q != TO_C) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign stale_o = (cnt_q == TO_C);

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= TO_C);

  // One measurement per frame edge (R5)
  p_one_meas_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    meas_vld_o |=> !meas_vld_o);

  // A measurement only follows an edge seen one cycle before (R8)
  p_meas_after_edge_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(meas_vld_o) |-> $past(rise_i));

endmodule

// File: rtl/rbd_classifier.sv
module rbd_classifier
  import rbd_pkg::*;
#(
  parameter int CW   = 7,
  parameter int TH_S = 40,
  parameter int TH_D = 20,
  parameter int TH_Q = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          meas_vld_i,
  input  logic [CW-1:0] period_i,
  input  logic          stale_i,
  output speed_t        det_mode_o,
  output logic          locked_o
);

  localparam logic [CW-1:0] TH_S_C = CW'(TH_S);
  localparam logic [CW-1:0] TH_D_C = CW'(TH_D);
  localparam logic [CW-1:0] TH_Q_C = CW'(TH_Q);

  logic   band_ok;
  speed_t band_spd;
  speed_t cand_q;
  logic   cand_ok_q;

  always_comb begin
    band_ok  = 1'b1;
    band_spd = SPD_SINGLE;
    if (period_i >= TH_S_C)      band_spd = SPD_SINGLE;
    else if (period_i >= TH_D_C) band_spd = SPD_DOUBLE;
    else if (period_i >= TH_Q_C) band_spd = SPD_QUAD;
    else                         band_ok  = 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cand_q     <= SPD_SINGLE;
      cand_ok_q  <= 1'b0;
      det_mode_o <= SPD_SINGLE;
      locked_o   <= 1'b0;
    end else if (stale_i) begin
      cand_ok_q <= 1'b0;
      locked_o  <= 1'b0;
    end else if (meas_vld_i) begin
      if (!band_ok) begin
        cand_ok_q <= 1'b0;
        locked_o  <= 1'b0;
      end else if (cand_ok_q && (cand_q == band_spd)) begin
        det_mode_o <= band_spd;
        locked_o   <= 1'b1;
      end else begin
        cand_q    <= band_spd;
        cand_ok_q <= 1'b1;
      end
    end
  end

  p_fast_unlocks_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (meas_vld_i && !band_ok) |=> !locked_o);

  p_hold_mode_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !meas_vld_i |=> $stable(det_mode_o));

  p_lock_from_meas_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(locked_o) |-> $past(meas_vld_i));

  p_stale_unlocks_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    stale_i |=> !locked_o);

endmodule

// File: rtl/rate_band_detector.sv
module rate_band_detector
  import rbd_pkg::*;
#(
  parameter int REF_HZ      = 24576000,
  parameter int SS_MAX_HZ   = 50000,
  parameter int DS_MAX_HZ   = 100000,
  parameter int QS_MAX_HZ   = 200000,
  parameter int MIN_RATE_HZ = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             lrck_i,
  input  logic             auto_en_i,
  input  logic [1:0]       force_mode_i,
  output logic [1:0]       mode_o,
  output logic [OSR_W-1:0] osr_o,
  output logic             lock_o
);

  localparam int TH_S   = (REF_HZ + SS_MAX_HZ - 1) / SS_MAX_HZ;
  localparam int TH_D   = (REF_HZ + DS_MAX_HZ - 1) / DS_MAX_HZ;
  localparam int TH_Q   = (REF_HZ + QS_MAX_HZ - 1) / QS_MAX_HZ;
  localparam int TO_CYC = (REF_HZ + MIN_RATE_HZ - 1) / MIN_RATE_HZ;
  localparam int CW     = $clog2(TO_CYC + 1);

  logic          rise;
  logic          meas_vld;
  logic [CW-1:0] period;
  logic          stale;
  speed_t        det_mode;
  logic          det_locked;
  speed_t        sel_mode;

  rbd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (lrck_i),
    .rise_o  (rise)
  );

  rbd_period_meter #(.TO_CYC(TO_CYC), .CW(CW)) u_meter (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rise_i     (rise),
    .meas_vld_o (meas_vld),
    .period_o   (period),
    .stale_o    (stale)
  );

  rbd_classifier #(.CW(CW), .TH_S(TH_S), .TH_D(TH_D), .TH_Q(TH_Q)) u_class (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .meas_vld_i (meas_vld),
    .period_i   (period),
    .stale_i    (stale),
    .det_mode_o (det_mode),
    .locked_o   (det_locked)
  );

  assign sel_mode = auto_en_i ? det_mode : decode_force(force_mode_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_o <= SPD_SINGLE;
      osr_o  <= 8'd128;
      lock_o <= 1'b0;
    end else begin
      mode_o <= sel_mode;
      osr_o  <= osr_of(sel_mode);
      lock_o <= det_locked;
    end
  end

  p_legal_code_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_o != 2'b11);

  p_osr_tracks_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    osr_o == ((mode_o == 2'b01) ? 8'd64 : (mode_o == 2'b10) ? 8'd32 : 8'd128));

  p_force_path_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(auto_en_i)) |->
      (mode_o == (($past(force_mode_i) == 2'b11) ? 2'b00 : $past(force_mode_i))));

  p_lock_follows_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (lock_o == $past(det_locked)));

endmodule

// File: tb/rate_band_detector_tb.sv
`timescale 1ns/1ps
module rate_band_detector_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lrck = 1'b0;
  logic       auto_en = 1'b1;
  logic [1:0] force_mode = 2'b00;
  logic [1:0] mode;
  logic [7:0] osr;
  logic       lock;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rate_band_detector #(
    .REF_HZ      (2000000),
    .MIN_RATE_HZ (20000)
  ) u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .lrck_i       (lrck),
    .auto_en_i    (auto_en),
    .force_mode_i (force_mode),
    .mode_o       (mode),
    .osr_o        (osr),
    .lock_o       (lock)
  );

  // thresholds for this build: single 40, double 20, quad 10 cycles
  function automatic int band_of(int g);
    if (g >= 40) return 0;
    if (g >= 20) return 1;
    if (g >= 10) return 2;
    return 3;
  endfunction

  task automatic chk(string req, logic [1:0] em, logic el);
    logic [7:0] eo;
    eo = 8'd128 >> em;
    tests++;
    if (mode !== em || osr !== eo || lock !== el) begin
      fails++;
      $display("FAIL %s: mode=%0d osr=%0d lock=%0d expected mode=%0d osr=%0d lock=%0d",
               req, mode, osr, lock, em, eo, el);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst  = 1'b1;
    lrck = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  // rising edge spaced g cycles after the previous one, then 6 high cycles
  task automatic pulse(int g);
    lrck = 1'b0;
    repeat (g - 6) @(negedge clk);
    lrck = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 2'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 2'd0, 1'b0);

    // R3 R4 R5 R8: sweep every edge spacing across all bands
    for (int g = 8; g <= 60; g++) begin
      int b;
      do_reset();
      b = band_of(g);
      pulse(g);
      pulse(g);
      chk("R5 R8 one measurement no lock", 2'd0, 1'b0);
      pulse(g);
      if (b == 3) chk("R4 too fast", 2'd0, 1'b0);
      else        chk("R3 R2 band select", 2'(b), 1'b1);
    end

    // R5: alternating bands do not move the committed mode
    do_reset();
    pulse(50); pulse(50); pulse(50);
    chk("R5 lock single", 2'd0, 1'b1);
    pulse(30); chk("R5 alt 1", 2'd0, 1'b1);
    pulse(50); chk("R5 alt 2", 2'd0, 1'b1);
    pulse(30); chk("R5 alt 3", 2'd0, 1'b1);
    pulse(50); chk("R5 alt 4", 2'd0, 1'b1);
    pulse(30); chk("R5 first double", 2'd0, 1'b1);
    pulse(30); chk("R5 second double", 2'd1, 1'b1);

    // R6: frame clock stops
    lrck = 1'b0;
    repeat (150) @(negedge clk);
    chk("R6 timeout holds mode", 2'd1, 1'b0);
    pulse(30); pulse(30);
    chk("R6 two edges after timeout", 2'd1, 1'b0);
    pulse(30);
    chk("R6 relock", 2'd1, 1'b1);

    // R4: too fast while locked
    pulse(15); pulse(15);
    chk("R3 quad lock", 2'd2, 1'b1);
    pulse(8);
    chk("R4 fast drops lock, holds mode", 2'd2, 1'b0);

    // R7: forced modes
    auto_en = 1'b0;
    for (int f = 0; f < 4; f++) begin
      force_mode = 2'(f);
      @(negedge clk);
      @(negedge clk);
      chk("R7 forced", (f == 3) ? 2'd0 : 2'(f), 1'b0);
    end
    force_mode = 2'b01;
    @(negedge clk);
    auto_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 back to auto", 2'd2, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule